// File: doc/BRIEF.md
# Conditional Relative Branch Executor

This block resolves the two-byte relative branches of an 8-bit accumulator processor. When the block is idle, the sequencer presents a branch opcode and its signed 8-bit displacement on one cycle with a start strobe. It also presents the six condition flags, the level of the external interrupt pin and the address of the branch instruction. The block captures all of these inputs when it accepts the start strobe. It then decides whether the condition holds and works out where execution continues.

A legal branch always occupies three bus cycles, whether or not it is taken. The block raises `busy_o` for those three cycles. In the last of them it gives a one-cycle `done_o` pulse, and at that point `next_pc_o` and `taken_o` hold the result. Both outputs keep their values until the next result replaces them.

An opcode outside the branch set finishes one cycle after the start strobe. It sets `illegal_o` together with `done_o`, and the program counter stays at the instruction address. The block never alters the flags; it only reads them.

Top module: `branch_exec`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge, the block clears `busy_o`, `done_o`, `illegal_o` and `taken_o` after that edge and sets `next_pc_o` to 0. This also applies when a branch is in progress.
- R2: The block accepts `start_i` only when `busy_o` is low. For a legal opcode, `busy_o` is high for exactly 3 consecutive cycles after the accepting edge. `done_o` is high for exactly one cycle, which is the third of those cycles.
- R3: While `busy_o` is high, the block ignores `start_i`, `opcode_i`, `offset_i`, `flags_i`, `irq_pin_i` and `pc_i`. The result depends only on the values captured at acceptance, and the block goes idle after its third busy cycle.
- R4: For a taken branch, `next_pc_o` equals `pc_i` + 2 + the sign-extended `offset_i`, modulo 2^16.
- R5: For a branch that is not taken, `next_pc_o` equals `pc_i` + 2, modulo 2^16.
- R6: Opcode 0x20 is always taken. Opcode 0x22 is taken when (C or Z) is 0, and opcode 0x23 is taken when (C or Z) is 1. The bit layout of `flags_i` is: bit 5 V, bit 4 H, bit 3 I, bit 2 N, bit 1 Z, bit 0 C.
- R7: Opcode 0x24 is taken when C is 0 and opcode 0x25 is taken when C is 1. Opcode 0x26 is taken when Z is 0 and opcode 0x27 is taken when Z is 1.
- R8: Opcodes 0x28 and 0x29 are taken when H is 0 and 1 respectively. Opcodes 0x2A and 0x2B are taken when N is 0 and 1 respectively. Opcodes 0x2C and 0x2D are taken when I is 0 and 1 respectively.
- R9: Opcode 0x2E is taken when `irq_pin_i` is 0, and opcode 0x2F is taken when it is 1.
- R10: Opcode 0x90 is taken when (N xor V) is 0 and opcode 0x91 when it is 1. Opcode 0x92 is taken when (Z or (N xor V)) is 0 and opcode 0x93 when it is 1.
- R11: Every other opcode, 0x21 included, is illegal. One cycle after acceptance the block raises `done_o` and `illegal_o` together for one cycle, with `busy_o` low, `taken_o` at 0 and `next_pc_o` equal to the captured `pc_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only while idle |
| opcode_i | input | 8 | Branch opcode |
| offset_i | input | 8 | Signed displacement byte |
| flags_i | input | 6 | Condition flags {V,H,I,N,Z,C} |
| irq_pin_i | input | 1 | Level of the external interrupt pin |
| pc_i | input | 16 | Address of the branch instruction |
| busy_o | output | 1 | High during the three branch cycles |
| done_o | output | 1 | One-cycle completion pulse |
| taken_o | output | 1 | Condition held, valid from `done_o` |
| illegal_o | output | 1 | Opcode outside the branch set |
| next_pc_o | output | 16 | Next program counter, valid from `done_o` |

## Verification
A wrong internal state shows up at the ports in one of three ways.
- If the cycle counter is wrong, `done_o` appears one cycle early or late, or `busy_o` never drops. The bench detects this in the first transaction after the fault.
- If a decode or flag-selection error occurs, only one opcode and flag combination gets the wrong `taken_o`, and `next_pc_o` then differs by exactly the sign-extended displacement. This is why the sweep covers every legal opcode against all 128 combinations of flags and pin.
- If a capture register loads during busy, `next_pc_o` reflects the values driven mid-branch, which the bench deliberately scrambles.

// File: rtl/branch_pkg.sv
// Package: shared types for the relative branch executor.
// Assumes the flag vector layout {V,H,I,N,Z,C}, with C in bit 0.
package branch_pkg;
    localparam int FLAG_W = 6;
    localparam int FLG_C  = 0;
    localparam int FLG_Z  = 1;
    localparam int FLG_N  = 2;
    localparam int FLG_I  = 3;
    localparam int FLG_H  = 4;
    localparam int FLG_V  = 5;

    // Which test a decoded branch applies; the polarity bit picks 0 or 1.
    typedef enum logic [3:0] {
        COND_ALWAYS,
        COND_CZ,
        COND_C,
        COND_Z,
        COND_H,
        COND_N,
        COND_I,
        COND_PIN,
        COND_LT,
        COND_LE
    } cond_t;
endpackage

// File: rtl/branch_decode.sv
// Module: branch_decode
// Maps an 8-bit opcode to a condition selector and a polarity, and flags
// legality. Purely combinational. Assumes that in the 0x2x range bit 0 is
// the polarity and bits 3:1 select the test, and that 0x90..0x93 are the
// signed compares with bit 1 choosing the form that includes Z.
module branch_decode
    import branch_pkg::*;
(
    input  logic [7:0] opcode_i,
    output logic       legal_o,
    output cond_t      cond_o,
    output logic       pol_o
);
    // Decode the opcode into a test and the value that makes it succeed.
    always_comb begin
        legal_o = 1'b0;
        cond_o  = COND_ALWAYS;
        pol_o   = opcode_i[0];
        if (opcode_i[7:4] == 4'h2) begin
            legal_o = !((opcode_i[3:1] == 3'd0) && opcode_i[0]);
            case (opcode_i[3:1])
                3'd0:    cond_o = COND_ALWAYS;
                3'd1:    cond_o = COND_CZ;
                3'd2:    cond_o = COND_C;
                3'd3:    cond_o = COND_Z;
                3'd4:    cond_o = COND_H;
                3'd5:    cond_o = COND_N;
                3'd6:    cond_o = COND_I;
                default: cond_o = COND_PIN;
            endcase
        end else if (opcode_i[7:2] == 6'b100100) begin
            legal_o = 1'b1;
            cond_o  = opcode_i[1] ? COND_LE : COND_LT;
        end
    end
endmodule

// File: rtl/branch_cond_eval.sv
// Module: branch_cond_eval
// Evaluates the selected test on the captured flags and the pin level. The
// branch is taken when the test result equals the polarity bit; for the
// unconditional case the test reads 0 and the polarity is 0.
module branch_cond_eval
    import branch_pkg::*;
(
    input  cond_t             cond_i,
    input  logic              pol_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              pin_i,
    output logic              taken_o
);
    logic test;
    logic sgn_lt;

    // Signed less-than term shared by both signed compares.
    assign sgn_lt = flags_i[FLG_N] ^ flags_i[FLG_V];

    // Select the raw test value for the decoded condition.
    always_comb begin
        case (cond_i)
            COND_CZ:  test = flags_i[FLG_C] | flags_i[FLG_Z];
            COND_C:   test = flags_i[FLG_C];
            COND_Z:   test = flags_i[FLG_Z];
            COND_H:   test = flags_i[FLG_H];
            COND_N:   test = flags_i[FLG_N];
            COND_I:   test = flags_i[FLG_I];
            COND_PIN: test = pin_i;
            COND_LT:  test = sgn_lt;
            COND_LE:  test = flags_i[FLG_Z] | sgn_lt;
            default:  test = 1'b0;
        endcase
    end

    assign taken_o = (test == pol_i);
endmodule

// File: rtl/branch_target.sv
// Module: branch_target
// Forms the fall-through address (instruction address + 2) and the taken
// target (fall-through + sign-extended displacement), both wrapping at
// ADDR_W bits. Assumes OFS_W < ADDR_W.
module branch_target #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic              taken_i,
    output logic [ADDR_W-1:0] next_pc_o
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] seq_pc;
    logic [ADDR_W-1:0] ofs_ext;

    assign seq_pc    = pc_i + ADDR_W'(2);
    assign ofs_ext   = {{EXT_W{offset_i[OFS_W-1]}}, offset_i};
    assign next_pc_o = taken_i ? (seq_pc + ofs_ext) : seq_pc;
endmodule

// File: rtl/branch_seq.sv
// Module: branch_seq
// Cycle sequencer. A legal start holds busy for CYCLES cycles, and done
// marks the last of them. An illegal start gives a one-cycle done and an
// illegal pulse with no busy. Assumes CYCLES >= 2.
module branch_seq #(
    parameter int CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic legal_i,
    output logic accept_o,
    output logic load_o,
    output logic busy_o,
    output logic done_o,
    output logic illegal_o
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             ill_q;

    assign busy_o    = (cnt_q != '0);
    assign accept_o  = start_i && !busy_o;
    assign load_o    = (cnt_q == CNT_W'(CYCLES - 1));
    assign illegal_o = ill_q;
    assign done_o    = (cnt_q == CNT_W'(CYCLES)) || ill_q;

    // Advance the busy-cycle counter and register the illegal pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ill_q <= 1'b0;
        end else begin
            ill_q <= accept_o && !legal_i;
            if (accept_o && legal_i)
                cnt_q <= CNT_W'(1);
            else if (cnt_q == CNT_W'(CYCLES))
                cnt_q <= '0;
            else if (busy_o)
                cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/branch_exec.sv
// Module: branch_exec (top)
// Relative branch executor. It captures the operands on an accepted start,
// evaluates the condition on the captured copy, and registers next PC and
// taken one cycle before done. Assumes an 8-bit opcode and that the
// caller holds start for one cycle per branch.
module branch_exec
    import branch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    parameter int CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [7:0]        opcode_i,
    input  logic [OFS_W-1:0]  offset_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic              irq_pin_i,
    input  logic [ADDR_W-1:0] pc_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              taken_o,
    output logic              illegal_o,
    output logic [ADDR_W-1:0] next_pc_o
);
    logic              dec_legal;
    cond_t             dec_cond;
    logic              dec_pol;
    logic              accept;
    logic              load;

    cond_t             cond_q;
    logic              pol_q;
    logic [FLAG_W-1:0] flags_q;
    logic              pin_q;
    logic [ADDR_W-1:0] pc_q;
    logic [OFS_W-1:0]  ofs_q;

    logic              taken_w;
    logic [ADDR_W-1:0] target_w;
    logic [ADDR_W-1:0] res_pc_q;
    logic              res_taken_q;

    branch_decode u_dec (
        .opcode_i (opcode_i),
        .legal_o  (dec_legal),
        .cond_o   (dec_cond),
        .pol_o    (dec_pol)
    );

    branch_seq #(.CYCLES(CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .legal_i   (dec_legal),
        .accept_o  (accept),
        .load_o    (load),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .illegal_o (illegal_o)
    );

    // Capture the operands of an accepted legal branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cond_q  <= COND_ALWAYS;
            pol_q   <= 1'b0;
            flags_q <= '0;
            pin_q   <= 1'b0;
            pc_q    <= '0;
            ofs_q   <= '0;
        end else if (accept && dec_legal) begin
            cond_q  <= dec_cond;
            pol_q   <= dec_pol;
            flags_q <= flags_i;
            pin_q   <= irq_pin_i;
            pc_q    <= pc_i;
            ofs_q   <= offset_i;
        end
    end

    branch_cond_eval u_eval (
        .cond_i  (cond_q),
        .pol_i   (pol_q),
        .flags_i (flags_q),
        .pin_i   (pin_q),
        .taken_o (taken_w)
    );

    branch_target #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_tgt (
        .pc_i      (pc_q),
        .offset_i  (ofs_q),
        .taken_i   (taken_w),
        .next_pc_o (target_w)
    );

    // Register the result: branch outcome on load, unchanged PC on illegal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_pc_q    <= '0;
            res_taken_q <= 1'b0;
        end else if (accept && !dec_legal) begin
            res_pc_q    <= pc_i;
            res_taken_q <= 1'b0;
        end else if (load) begin
            res_pc_q    <= target_w;
            res_taken_q <= taken_w;
        end
    end

    assign next_pc_o = res_pc_q;
    assign taken_o   = res_taken_q;
endmodule

// File: rtl/branch_exec_chk.sv
// Module: branch_exec_chk
// Property checker bound to branch_exec. It keeps its own copy of the
// accepted address and displacement, and its own busy-cycle count, and it
// checks the results and timing at the ports against them.
module branch_exec_chk #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8,
    parameter int CYCLES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              legal_i,
    input logic [OFS_W-1:0]  offset_i,
    input logic [ADDR_W-1:0] pc_i,
    input logic              busy_o,
    input logic              done_o,
    input logic              taken_o,
    input logic              illegal_o,
    input logic [ADDR_W-1:0] next_pc_o
);
    localparam int CW = $clog2(CYCLES + 1) + 1;

    logic [ADDR_W-1:0] ref_pc;
    logic [OFS_W-1:0]  ref_ofs;
    logic [CW-1:0]     busy_cnt;
    logic [ADDR_W-1:0] ref_ext;

    assign ref_ext = {{(ADDR_W-OFS_W){ref_ofs[OFS_W-1]}}, ref_ofs};

    // Record the operands at each accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_pc  <= '0;
            ref_ofs <= '0;
        end else if (start_i && !busy_o) begin
            ref_pc  <= pc_i;
            ref_ofs <= offset_i;
        end
    end

    // Count consecutive busy cycles already seen.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else        busy_cnt <= busy_o ? busy_cnt + CW'(1) : '0;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !illegal_o));

    assert_done_last_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o) |-> (busy_o && busy_cnt == CW'(CYCLES - 1)));

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < CW'(CYCLES)));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_legal_starts_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && legal_i) |=> (busy_o && !done_o));

    assert_taken_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o && taken_o) |-> (next_pc_o == ADDR_W'(ref_pc + ADDR_W'(2) + ref_ext)));

    assert_fallthrough_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !illegal_o && !taken_o) |-> (next_pc_o == ADDR_W'(ref_pc + ADDR_W'(2))));

    assert_illegal_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (done_o && !busy_o && !taken_o && next_pc_o == ref_pc));
endmodule

bind branch_exec branch_exec_chk #(
    .ADDR_W(ADDR_W), .OFS_W(OFS_W), .CYCLES(CYCLES)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .legal_i   (dec_legal),
    .offset_i  (offset_i),
    .pc_i      (pc_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .taken_o   (taken_o),
    .illegal_o (illegal_o),
    .next_pc_o (next_pc_o)
);

// File: tb/branch_exec_tb.sv
`timescale 1ns/1ps
// Bench: sweeps every opcode; legal ones run against all flag/pin combinations.
module branch_exec_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  opcode_i = '0;
    logic [7:0]  offset_i = '0;
    logic [5:0]  flags_i = '0;
    logic        irq_pin_i = 1'b0;
    logic [15:0] pc_i = '0;
    logic        busy_o, done_o, taken_o, illegal_o;
    logic [15:0] next_pc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    branch_exec dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .offset_i(offset_i), .flags_i(flags_i), .irq_pin_i(irq_pin_i),
        .pc_i(pc_i), .busy_o(busy_o), .done_o(done_o), .taken_o(taken_o),
        .illegal_o(illegal_o), .next_pc_o(next_pc_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_branch(input logic [7:0] op);
        return (op == 8'h20) || (op >= 8'h22 && op <= 8'h2F) || (op >= 8'h90 && op <= 8'h93);
    endfunction

    // Reference condition, written per opcode from the requirement list.
    function automatic bit ref_taken(input logic [7:0] op, input logic [5:0] f, input logic pin);
        logic v, h, i, n, z, c;
        {v, h, i, n, z, c} = f;
        case (op)
            8'h20: return 1'b1;
            8'h22: return !(c | z);
            8'h23: return c | z;
            8'h24: return !c;
            8'h25: return c;
            8'h26: return !z;
            8'h27: return z;
            8'h28: return !h;
            8'h29: return h;
            8'h2A: return !n;
            8'h2B: return n;
            8'h2C: return !i;
            8'h2D: return i;
            8'h2E: return !pin;
            8'h2F: return pin;
            8'h90: return !(n ^ v);
            8'h91: return n ^ v;
            8'h92: return !(z | (n ^ v));
            8'h93: return z | (n ^ v);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string group_of(input logic [7:0] op);
        if (op == 8'h20 || op == 8'h22 || op == 8'h23) return "R6";
        if (op >= 8'h24 && op <= 8'h27) return "R7";
        if (op >= 8'h28 && op <= 8'h2D) return "R8";
        if (op == 8'h2E || op == 8'h2F) return "R9";
        return "R10";
    endfunction

    // Run one legal branch, scrambling inputs while busy (R3).
    task automatic run_legal(input logic [7:0] op, input logic [5:0] f, input logic pin,
                             input logic [15:0] addr, input logic [7:0] ofs);
        bit          tk;
        logic [15:0] exp_pc;
        tk     = ref_taken(op, f, pin);
        exp_pc = addr + 16'd2 + (tk ? {{8{ofs[7]}}, ofs} : 16'd0);
        start_i = 1'b1; opcode_i = op; flags_i = f; irq_pin_i = pin; pc_i = addr; offset_i = ofs;
        for (int k = 1; k <= 2; k++) begin
            @(negedge clk);
            check(busy_o && !done_o, "R2", $sformatf("busy cycle %0d op %02h", k, op),
                  {busy_o, done_o}, 2'b10);
            opcode_i = ~op; flags_i = ~f; irq_pin_i = ~pin; pc_i = ~addr; offset_i = ~ofs;
            start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o && done_o && !illegal_o, "R2", $sformatf("done cycle op %02h", op),
              {busy_o, done_o, illegal_o}, 3'b110);
        check(taken_o == tk, group_of(op), $sformatf("taken op %02h f %02h pin %0d", op, f, pin),
              taken_o, tk);
        check(next_pc_o == exp_pc, tk ? "R4" : "R5",
              $sformatf("next pc op %02h at %04h ofs %02h", op, addr, ofs), next_pc_o, exp_pc);
        @(negedge clk);
        check(!busy_o && !done_o && next_pc_o == exp_pc, "R3", "idle after 3 cycles, result held",
              {busy_o, done_o, next_pc_o}, {2'b00, exp_pc});
    endtask

    // Run one illegal opcode (R11).
    task automatic run_illegal(input logic [7:0] op, input logic [5:0] f, input logic [15:0] addr);
        start_i = 1'b1; opcode_i = op; flags_i = f; irq_pin_i = f[0]; pc_i = addr; offset_i = op;
        @(negedge clk);
        start_i = 1'b0;
        check(done_o && illegal_o && !busy_o && !taken_o, "R11",
              $sformatf("illegal flags op %02h", op),
              {done_o, illegal_o, busy_o, taken_o}, 4'b1100);
        check(next_pc_o == addr, "R11", $sformatf("pc kept op %02h", op), next_pc_o, addr);
        @(negedge clk);
        check(!done_o && !illegal_o, "R11", "illegal pulse one cycle",
              {done_o, illegal_o}, 2'b00);
    endtask

    task automatic summary;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        start_i = 1'b1; opcode_i = 8'h20;
        repeat (3) @(negedge clk);
        check(!busy_o && !done_o && !illegal_o && !taken_o && next_pc_o == 16'h0, "R1",
              "reset state", {busy_o, done_o, illegal_o, taken_o, next_pc_o}, 20'h0);
        rst_n = 1'b1; start_i = 1'b0;
        @(negedge clk);

        // Directed wrap cases for R4.
        run_legal(8'h20, 6'h00, 1'b0, 16'hFFFF, 8'h05);
        run_legal(8'h20, 6'h00, 1'b0, 16'h0001, 8'h80);
        run_legal(8'h20, 6'h00, 1'b0, 16'h1234, 8'h7F);
        run_legal(8'h26, 6'h02, 1'b0, 16'hFFFE, 8'hF0); // R5 wrap when not taken

        // Full sweep.
        for (int op = 0; op < 256; op++) begin
            if (is_branch(8'(op))) begin
                for (int j = 0; j < 128; j++)
                    run_legal(8'(op), 6'(j), j[6], 16'(j * 16'h0A31 + op * 16'h0101),
                              8'(j * 37 + op));
            end else begin
                run_illegal(8'(op), 6'(op), 16'(op * 16'h0307 + 16'hF0F0));
                run_illegal(8'(op), 6'(~op), 16'(op * 16'h1111));
            end
        end

        // R1: reset while a branch is in progress.
        start_i = 1'b1; opcode_i = 8'h20; pc_i = 16'h4000; offset_i = 8'h10;
        @(negedge clk);
        start_i = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !taken_o && next_pc_o == 16'h0, "R1", "reset mid-branch",
              {busy_o, done_o, taken_o, next_pc_o}, 19'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o, "R1", "idle after reset", {busy_o, done_o}, 2'b00);

        finished = 1;
        summary();
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule